// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked sequencer. It turns single-word host requests into the strobe sequence for an external asynchronous static memory that is 16 bits wide. The memory is reached through a 19-bit word address. It has two chip selects of opposite polarity, an output enable, a write enable, one active-low enable per byte lane, and a shared tri-state data bus. The host presents an address, a write flag, a two-bit lane mask and write data. A request is taken when both `req` and `ready` are high at a rising clock edge.

Every phase of a memory cycle is timed by counting clocks. A write follows a fixed order. The controller first selects the part and drives the address and lane enables. It then holds the write enable low for `N_WP` clocks and drives only the enabled lanes. At the end it releases the write enable, the selects and the lane enables together, and holds the address for `N_WR` more clocks. A read keeps the output enable and the selects asserted for `N_RD` clocks and captures the bus on the last of them. It then returns the captured word with a one-cycle valid strobe and inserts one turnaround clock before the controller becomes idle again. The three counts are chosen so that the memory's access time and write pulse width are met at the clock in use.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_be_n`=2'b11, `ready`=1, `rvalid`=0 and the controller does not drive `mem_dq`.
- R2: A request is accepted only at an edge where `req` and `ready` are both high. `ready` stays low from that edge until the cycle is over. A request raised while `ready` is low has no effect.
- R3: In the clock before `mem_we_n` falls, the part is already selected (`mem_cs_n`=0, `mem_cs`=1), and the write address and lane enables are already on the pins. The address stays stable for as long as `mem_we_n` is low.
- R4: `mem_we_n` is low for exactly `N_WP` consecutive clocks per write.
- R5: A write ends at one edge, where `mem_we_n`, `mem_be_n` (to 2'b11) and the selects all deassert. The address is then held for `N_WR` clocks, and `ready` returns `N_WP+N_WR+2` clocks after the accepting edge.
- R6: Mask bit 0 enables the lower lane (`mem_be_n[0]`, `mem_dq[7:0]`). Mask bit 1 enables the upper lane (`mem_be_n[1]`, `mem_dq[15:8]`). Only enabled lanes of the memory change on a write, and a mask of 2'b00 changes nothing.
- R7: A read holds `mem_oe_n` low with the part selected for `N_RD` clocks. It captures the bus on the last of those clocks and raises `rvalid` for one clock, `N_RD+1` clocks after the accepting edge.
- R8: A lane not enabled by the read mask returns zero in `rdata`, so a read with mask 2'b00 returns 16'h0000.
- R9: The controller drives `mem_dq` only while `mem_we_n` is low, and `mem_oe_n` and `mem_we_n` are never low together.
- R10: After the read capture, one turnaround clock passes with the output enable high before `ready` returns, `N_RD+2` clocks after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request |
| ready | output | 1 | Controller idle, request can be taken |
| wr | input | 1 | 1 = write, 0 = read |
| mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, unselected lanes zero |
| rvalid | output | 1 | One-clock read data strobe |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_cs | output | 1 | Memory select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 lower |
| mem_addr | output | 19 | Memory address |
| mem_dq | inout | 16 | Memory data bus |

## Verification
The assertions take for granted that the memory drives `mem_dq` only while it is selected with the output enable low, the write enable high and the lane enabled. They also assume that the host holds its request fields steady during the clock in which `req` is high. The stimulus keeps to both assumptions. It raises `req` and changes the fields only at falling edges while the controller is idle, except for one deliberate request pulsed while the controller is busy. A behavioural memory model in the bench tri-states each lane with exactly those conditions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WRECOV = 3'd3,
        PH_RACC   = 3'd4,
        PH_TURN   = 3'd5
    } phase_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    assert_timer_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 2,
    parameter int CNT_W  = 3,
    parameter int N_WP   = 3,
    parameter int N_WR   = 1,
    parameter int N_RD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [LANES-1:0]  mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              w_accept,
    output logic              rd_sample,
    output logic              ready,
    output logic              drive,
    output logic              cs_n,
    output logic              cs,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  be_n,
    output logic [ADDR_W-1:0] mem_addr
);
    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   addr;
        logic                cs_n;
        logic                cs;
        logic                oe_n;
        logic                we_n;
        logic [LANES-1:0]    be_n;
        logic                drive;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_IDLE, addr: '0, cs_n: 1'b1, cs: 1'b0,
                                 oe_n: 1'b1, we_n: 1'b1, be_n: '1, drive: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        w_accept  = 1'b0;
        rd_sample = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req) begin
                    seq_d.addr = addr;
                    seq_d.cs_n = 1'b0;
                    seq_d.cs   = 1'b1;
                    seq_d.be_n = ~mask;
                    if (wr) begin
                        seq_d.ph = PH_WSETUP;
                        w_accept = 1'b1;
                    end else begin
                        seq_d.ph   = PH_RACC;
                        seq_d.oe_n = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(N_RD - 1);
                    end
                end
            end
            PH_WSETUP: begin
                seq_d.ph    = PH_WPULSE;
                seq_d.we_n  = 1'b0;
                seq_d.drive = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(N_WP - 1);
            end
            PH_WPULSE: begin
                if (tmr_done) begin
                    seq_d.ph    = PH_WRECOV;
                    seq_d.we_n  = 1'b1;
                    seq_d.drive = 1'b0;
                    seq_d.cs_n  = 1'b1;
                    seq_d.cs    = 1'b0;
                    seq_d.be_n  = '1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(N_WR - 1);
                end
            end
            PH_WRECOV: begin
                if (tmr_done) seq_d.ph = PH_IDLE;
            end
            PH_RACC: begin
                if (tmr_done) begin
                    rd_sample  = 1'b1;
                    seq_d.ph   = PH_TURN;
                    seq_d.oe_n = 1'b1;
                    seq_d.cs_n = 1'b1;
                    seq_d.cs   = 1'b0;
                    seq_d.be_n = '1;
                end
            end
            PH_TURN: seq_d.ph = PH_IDLE;
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign ready    = (seq_q.ph == PH_IDLE);
    assign drive    = seq_q.drive;
    assign cs_n     = seq_q.cs_n;
    assign cs       = seq_q.cs;
    assign oe_n     = seq_q.oe_n;
    assign we_n     = seq_q.we_n;
    assign be_n     = seq_q.be_n;
    assign mem_addr = seq_q.addr;

    assert_busy_blocks_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && req) |=> ($stable(mem_addr) || (ready && !$past(ready) == 1'b0)));
    assert_we_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && cs));
    assert_setup_before_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ($stable(mem_addr) && !$past(cs_n) && $past(cs)));
    assert_oe_we_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int LANES = 2,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_accept,
    input  logic [DW-1:0]    wdata,
    input  logic             drive,
    input  logic             sample,
    input  logic [LANES-1:0] be_n,
    inout  wire  [DW-1:0]    mem_dq,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    localparam int LW = DW / LANES;

    typedef struct packed {
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic          rv;
    } lane_t;

    lane_t lio_d, lio_q;
    logic [DW-1:0] lane_rd;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_dq[g*LW +: LW]  = (drive && !be_n[g]) ? lio_q.wd[g*LW +: LW] : {LW{1'bz}};
        assign lane_rd[g*LW +: LW] = be_n[g] ? '0 : mem_dq[g*LW +: LW];
    end

    always_comb begin
        lio_d    = lio_q;
        lio_d.rv = 1'b0;
        if (w_accept) lio_d.wd = wdata;
        if (sample) begin
            lio_d.rd = lane_rd;
            lio_d.rv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lio_q <= '0;
        else        lio_q <= lio_d;
    end

    assign rdata  = lio_q.rd;
    assign rvalid = lio_q.rv;

    assert_rvalid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W = 19,
    parameter int DW     = 16,
    parameter int N_WP   = 3,
    parameter int N_WR   = 1,
    parameter int N_RD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [DW/8-1:0]   mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rvalid,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DW/8-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DW-1:0]     mem_dq
);
    localparam int LANES = DW / 8;
    localparam int N_MAX = (N_WP > N_WR) ? ((N_WP > N_RD) ? N_WP : N_RD)
                                         : ((N_WR > N_RD) ? N_WR : N_RD);
    localparam int CNT_W = $clog2(N_MAX + 1);
    localparam int RUN_W = $clog2(N_WP + 2);

    logic             tmr_load, tmr_done, w_accept, rd_sample, drive;
    logic [CNT_W-1:0] tmr_val;

    sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W),
               .N_WP(N_WP), .N_WR(N_WR), .N_RD(N_RD)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mask(mask), .addr(addr),
        .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .w_accept(w_accept), .rd_sample(rd_sample), .ready(ready), .drive(drive),
        .cs_n(mem_cs_n), .cs(mem_cs), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .be_n(mem_be_n), .mem_addr(mem_addr));

    sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

    sram_lane_io #(.LANES(LANES), .DW(DW)) u_io (
        .clk(clk), .rst_n(rst_n), .w_accept(w_accept), .wdata(wdata), .drive(drive),
        .sample(rd_sample), .be_n(mem_be_n), .mem_dq(mem_dq), .rdata(rdata), .rvalid(rvalid));

    // Checker state: length of the current write-enable-low run.
    logic [RUN_W-1:0] wp_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wp_run_q <= '0;
        else if (!mem_we_n) wp_run_q <= wp_run_q + 1'b1;
        else                wp_run_q <= '0;
    end

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wp_run_q == RUN_W'(N_WP)));
    assert_addr_steady_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
    assert_write_end_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_be_n == '1 && mem_cs_n && !mem_cs));
    assert_addr_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> $stable(mem_addr));
    assert_drive_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> !mem_we_n);
    assert_busy_when_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (!ready && mem_oe_n));

    initial begin
        assert_params_R4: assert (N_WP >= 1 && N_WR >= 1 && N_RD >= 1 && DW % 8 == 0);
    end
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
    localparam int N_WP = 3;
    localparam int N_WR = 1;
    localparam int N_RD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [1:0]  mask = 2'b00;
    logic [18:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ready, rvalid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
    logic [15:0] rdata;
    logic [1:0]  mem_be_n;
    logic [18:0] mem_addr;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    int both_low = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.N_WP(N_WP), .N_WR(N_WR), .N_RD(N_RD)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr), .mask(mask),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

    // Behavioural memory: 64 words indexed by the low address bits.
    logic [15:0] mem [64];
    wire         sel   = !mem_cs_n && mem_cs;
    wire  [5:0]  idx   = mem_addr[5:0];
    wire         rd_lo = sel && !mem_oe_n && mem_we_n && !mem_be_n[0];
    wire         rd_hi = sel && !mem_oe_n && mem_we_n && !mem_be_n[1];
    assign mem_dq[7:0]  = rd_lo ? mem[idx][7:0]  : 8'bz;
    assign mem_dq[15:8] = rd_hi ? mem[idx][15:8] : 8'bz;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

    always @(negedge clk) begin
        if (sel && !mem_we_n) begin
            if (!mem_be_n[0]) mem[idx][7:0]  <= mem_dq[7:0];
            if (!mem_be_n[1]) mem[idx][15:8] <= mem_dq[15:8];
        end
        if (rst_n && !mem_oe_n && !mem_we_n) both_low++;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One host operation with timing measurements relative to the accepting edge.
    task automatic do_op(input bit w, input logic [1:0] m, input logic [18:0] a,
                         input logic [15:0] d, output logic [15:0] got,
                         output int we_low, output int rv_at, output int done_at,
                         output bit setup_ok, output bit recov_ok, output bit hold_ok);
        int  n;
        bit  prev_we;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; mask = m; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wdata = 16'hxxxx;
        n = 1; we_low = 0; rv_at = 0; got = '0;
        setup_ok = 1'b0; recov_ok = !w; hold_ok = 1'b1; prev_we = 1'b1;
        while (!ready && n < 200) begin
            if (!mem_we_n) we_low++;
            if (!mem_we_n && mem_addr != a) hold_ok = 1'b0;
            if (rvalid) begin rv_at = n; got = rdata; end
            if (n == 1 && w)
                setup_ok = mem_we_n && !mem_cs_n && mem_cs && mem_addr == a && mem_be_n == ~m;
            if (!prev_we && mem_we_n)
                recov_ok = (mem_be_n == 2'b11) && mem_cs_n && !mem_cs && mem_addr == a;
            prev_we = mem_we_n;
            @(negedge clk);
            n++;
        end
        done_at = n;
    endtask

    typedef struct packed {
        logic        w;
        logic [1:0]  m;
        logic [18:0] a;
        logic [15:0] d;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b11, 19'h00001, 16'hA1B2, 16'h0000},
        '{1'b0, 2'b11, 19'h00001, 16'h0000, 16'hA1B2},
        '{1'b1, 2'b01, 19'h00001, 16'h55CC, 16'h0000},
        '{1'b0, 2'b11, 19'h00001, 16'h0000, 16'hA1CC},
        '{1'b1, 2'b10, 19'h00001, 16'h7700, 16'h0000},
        '{1'b0, 2'b11, 19'h00001, 16'h0000, 16'h77CC},
        '{1'b0, 2'b01, 19'h00001, 16'h0000, 16'h00CC},
        '{1'b0, 2'b10, 19'h00001, 16'h0000, 16'h7700},
        '{1'b1, 2'b11, 19'h7FFC2, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b11, 19'h7FFC2, 16'h0000, 16'hFFFF},
        '{1'b1, 2'b00, 19'h00001, 16'h0000, 16'h0000},
        '{1'b0, 2'b11, 19'h00001, 16'h0000, 16'h77CC},
        '{1'b0, 2'b00, 19'h00001, 16'h0000, 16'h0000}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] got;
        int wl, rva, dna;
        bit su, rc, ho;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && ready && !rvalid,
            "R1 reset outputs", {26'd0, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, ready, rvalid},
            {26'd0, 6'b101110});
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_we_n && mem_be_n == 2'b11, "R1 idle after reset",
            {29'd0, ready, mem_be_n}, 32'h7);

        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].w, VECS[v].m, VECS[v].a, VECS[v].d, got, wl, rva, dna, su, rc, ho);
            if (VECS[v].w) begin
                chk(wl == (VECS[v].m == 2'b00 ? N_WP : N_WP), "R4 pulse width", wl, N_WP);
                chk(su, "R3 setup before we", su, 1);
                chk(ho, "R3 address held in pulse", ho, 1);
                chk(rc, "R5 write end and recovery", rc, 1);
                chk(dna == N_WP + N_WR + 2, "R5 ready return", dna, N_WP + N_WR + 2);
            end else begin
                chk(got == VECS[v].exp, (VECS[v].m == 2'b11) ? "R6 read data" : "R8 lane zero",
                    got, VECS[v].exp);
                chk(rva == N_RD + 1, "R7 read latency", rva, N_RD + 1);
                chk(dna == N_RD + 2, "R10 turnaround", dna, N_RD + 2);
                chk(wl == 0, "R9 no write strobe in read", wl, 0);
            end
        end

        // R2: request pulsed while busy is ignored
        @(negedge clk);
        req = 1'b1; wr = 1'b1; mask = 2'b11; addr = 19'h00005; wdata = 16'h1234;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(!ready, "R2 busy", ready, 0);
        req = 1'b1; wdata = 16'hDEAD; addr = 19'h00006;
        @(negedge clk);
        chk(mem_addr == 19'h00005, "R2 address unchanged", mem_addr, 19'h00005);
        req = 1'b0;
        do_op(1'b0, 2'b11, 19'h00005, 16'h0, got, wl, rva, dna, su, rc, ho);
        chk(got == 16'h1234, "R2 busy request ignored", got, 16'h1234);
        do_op(1'b0, 2'b11, 19'h00006, 16'h0, got, wl, rva, dna, su, rc, ho);
        chk(got == 16'h0000, "R2 no stray write", got, 16'h0000);

        // R6: upper-lane-only write leaves lower lane of another word intact
        do_op(1'b1, 2'b10, 19'h7FFC2, 16'h3300, got, wl, rva, dna, su, rc, ho);
        do_op(1'b0, 2'b11, 19'h7FFC2, 16'h0, got, wl, rva, dna, su, rc, ho);
        chk(got == 16'h33FF, "R6 upper lane only", got, 16'h33FF);

        // R9: output and write enables never low together
        chk(both_low == 0, "R9 oe/we exclusive", both_low, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule